// File: doc/BRIEF.md
# Guarded Multiport Register File

This block is the general-purpose register store of a five-slot very long instruction word core. It holds 128 registers of 32 bits. Every issue slot reads three registers in the same cycle: one guard and two source operands, for fifteen reads per cycle in total. Each slot also owns one write port, so up to five results can land per clock. Reads are combinational. Writes land on the rising edge.

The core has no integer status flags. Compare operations write their outcome into ordinary registers, and a later operation names one of those registers as its guard. A slot's write lands only if bit 0 of its guard register is set. Register 0 is fixed at zero and register 1 is fixed at one. Naming register 1 as the guard therefore makes an operation unconditional, and naming register 0 turns it into a no-op.

When several slots commit to the same register in one cycle, the highest-numbered slot wins. A conflict indication is raised for one cycle so that the surrounding pipeline can observe the collision.

Top module: `gprf_top`

## Requirements
- R1: Each of the 128 registers is 32 bits wide. A value committed to register k (k from 2 to 127) is returned by any read port addressing k from the next cycle on, until another write to k commits.
- R2: All 15 read ports (guard, source A and source B of each of the 5 slots) return their addressed registers independently and combinationally in the same cycle.
- R3: A read of register 0 always returns 32'h0000_0000, and a read of register 1 always returns 32'h0000_0001.
- R4: A slot's write commits only when its write enable is 1 and bit 0 of the value read through that slot's guard port is 1. No other guard bit matters: a guard value of 32'hFFFF_FFFE blocks the write and 32'h0000_0003 allows it. Guard register 1 always allows a write and guard register 0 never does.
- R5: Writes addressed to register 0 or register 1 are discarded without effect.
- R6: When two or more slots commit to the same register in one cycle, the register takes the data of the highest-numbered of those slots.
- R7: `conflict_o` is 1 in the cycle after a cycle in which two or more slots committed to the same register, and 0 after any other cycle. Guarded-off and discarded writes do not count.
- R8: A read in the same cycle as a committing write to that register returns the value held before the write. There is no bypass path.
- R9: An active-low reset clears `conflict_o` immediately. Register contents are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the conflict flag |
| guard_addr_i | input | 5x7 | Guard register index per slot |
| guard_data_o | output | 5x32 | Guard register value per slot |
| srca_addr_i | input | 5x7 | First source register index per slot |
| srca_data_o | output | 5x32 | First source value per slot |
| srcb_addr_i | input | 5x7 | Second source register index per slot |
| srcb_data_o | output | 5x32 | Second source value per slot |
| wr_en_i | input | 5 | Write request per slot |
| wr_addr_i | input | 5x7 | Destination register index per slot |
| wr_data_i | input | 5x32 | Write data per slot |
| conflict_o | output | 1 | One-cycle pulse after a same-register multi-slot commit |

## Verification
A directed phase first fills every writable register through all five slots with register 1 as the guard. This shows that each port reaches every index. Directed cycles then set the guard to 0, to 1, to an even value with all upper bits set, and to an odd value. These separate a gate that tests bit 0 from one that tests the whole word. They also cover writes aimed at the two constant registers, two pairs of colliding slots (which show whether the lowest or the highest slot wins), and a reset in the cycle after a conflict, which shows the flag clearing while storage survives. Long random traffic follows. It concentrates write and guard indices on a small window so that collisions, guards just written, and read-during-write all occur often. Each of the fifteen reads is compared every cycle against a bench model that updates only at the clock edge.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  // Guard test: only the least significant bit of the guard word decides.
  function automatic logic guard_holds(input logic guard_lsb);
    return guard_lsb;
  endfunction

  // Register indices that are hardwired and never stored.
  function automatic logic is_fixed_reg(input int unsigned idx);
    return idx < 2;
  endfunction

  // Value read from a hardwired register (index 1 reads one, index 0 reads zero).
  function automatic logic fixed_value(input int unsigned idx);
    return idx == 1;
  endfunction

  // Two writes collide when both commit and both name the same index.
  function automatic logic writes_collide(input logic commit_a, input logic commit_b,
                                          input int unsigned idx_a, input int unsigned idx_b);
    return commit_a && commit_b && (idx_a == idx_b);
  endfunction

endpackage

// File: rtl/gprf_commit_gate.sv
module gprf_commit_gate
  import gprf_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 5,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_SLOTS-1:0]             wr_en_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] guard_val_i,
  output logic [NUM_SLOTS-1:0]             commit_o
);

  // The upper guard bits do not take part in the decision.
  logic [NUM_SLOTS-1:0] guard_lsb;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign guard_lsb[s] = guard_val_i[s][0];
    assign commit_o[s]  = wr_en_i[s]
                        && guard_holds(guard_lsb[s])
                        && !is_fixed_reg(32'(wr_addr_i[s]));
  end

endmodule

// File: rtl/gprf_conflict_detect.sv
module gprf_conflict_detect
  import gprf_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int NUM_SLOTS = 5,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_SLOTS-1:0]             commit_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] wr_addr_i,
  output logic [NUM_SLOTS-1:0]             overridden_o,
  output logic                             conflict_now_o
);

  // A slot is overridden when a higher-numbered slot commits to the same index.
  always_comb begin
    overridden_o   = '0;
    conflict_now_o = 1'b0;
    for (int lo = 0; lo < NUM_SLOTS; lo++) begin
      for (int hi = lo + 1; hi < NUM_SLOTS; hi++) begin
        if (writes_collide(commit_i[lo], commit_i[hi],
                           32'(wr_addr_i[lo]), 32'(wr_addr_i[hi]))) begin
          overridden_o[lo] = 1'b1;
          conflict_now_o   = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gprf_storage.sv
module gprf_storage
  import gprf_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 5,
  parameter int NUM_READS = 15,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic [NUM_SLOTS-1:0]             commit_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] wr_data_i,
  input  logic [NUM_READS-1:0][ADDR_W-1:0] rd_addr_i,
  output logic [NUM_READS-1:0][DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  // Slots are applied in ascending order, so the last (highest) committing slot wins.
  // No reset: contents persist across reset.
  always_ff @(posedge clk_i) begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (commit_i[s]) begin
        mem_q[wr_addr_i[s]] <= wr_data_i[s];
      end
    end
  end

  // Combinational reads with no bypass: a write in flight is not visible yet.
  for (genvar r = 0; r < NUM_READS; r++) begin : g_read
    assign rd_data_o[r] = is_fixed_reg(32'(rd_addr_i[r]))
                        ? DATA_W'(fixed_value(32'(rd_addr_i[r])))
                        : mem_q[rd_addr_i[r]];
  end

endmodule

// File: rtl/gprf_top.sv
module gprf_top
  import gprf_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 5,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] guard_addr_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] guard_data_o,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] srca_addr_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] srca_data_o,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] srcb_addr_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] srcb_data_o,
  input  logic [NUM_SLOTS-1:0]             wr_en_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] wr_data_i,
  output logic                             conflict_o
);

  localparam int PORTS_PER_SLOT = 3;
  localparam int NUM_READS      = NUM_SLOTS * PORTS_PER_SLOT;

  // Named internal events, also observed by the bound checker.
  logic [NUM_SLOTS-1:0]             slot_commit;
  logic [NUM_SLOTS-1:0]             slot_overridden;
  logic                             conflict_now;
  logic [NUM_READS-1:0][ADDR_W-1:0] rd_addr;
  logic [NUM_READS-1:0][DATA_W-1:0] rd_data;

  // Read port numbering: slot s uses 3s (guard), 3s+1 (source A) and 3s+2 (source B).
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_port_map
    assign rd_addr[PORTS_PER_SLOT*s]     = guard_addr_i[s];
    assign rd_addr[PORTS_PER_SLOT*s + 1] = srca_addr_i[s];
    assign rd_addr[PORTS_PER_SLOT*s + 2] = srcb_addr_i[s];
    assign guard_data_o[s] = rd_data[PORTS_PER_SLOT*s];
    assign srca_data_o[s]  = rd_data[PORTS_PER_SLOT*s + 1];
    assign srcb_data_o[s]  = rd_data[PORTS_PER_SLOT*s + 2];
  end

  gprf_commit_gate #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_gate (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .guard_val_i(guard_data_o),
    .commit_o   (slot_commit)
  );

  gprf_conflict_detect #(
    .NUM_REGS (NUM_REGS),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_conflict (
    .commit_i      (slot_commit),
    .wr_addr_i     (wr_addr_i),
    .overridden_o  (slot_overridden),
    .conflict_now_o(conflict_now)
  );

  gprf_storage #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_READS(NUM_READS)
  ) u_store (
    .clk_i    (clk_i),
    .commit_i (slot_commit),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conflict_o <= 1'b0;
    end else begin
      conflict_o <= conflict_now;
    end
  end

endmodule

// File: rtl/gprf_checker.sv
module gprf_checker #(
  parameter int NUM_REGS  = 128,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 5,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_SLOTS-1:0][ADDR_W-1:0] srca_addr_i,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] srca_data_o,
  input logic [NUM_SLOTS-1:0][ADDR_W-1:0] srcb_addr_i,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] srcb_data_o,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] guard_data_o,
  input logic [NUM_SLOTS-1:0]             wr_en_i,
  input logic [NUM_SLOTS-1:0][ADDR_W-1:0] wr_addr_i,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] wr_data_i,
  input logic [NUM_SLOTS-1:0]             slot_commit,
  input logic [NUM_SLOTS-1:0]             slot_overridden,
  input logic                             conflict_now,
  input logic                             conflict_o
);

  // Remember each slot's winning write for one cycle.
  logic [NUM_SLOTS-1:0]             win_valid_q;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] win_addr_q;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] win_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_q <= '0;
      win_addr_q  <= '0;
      win_data_q  <= '0;
    end else begin
      win_valid_q <= slot_commit & ~slot_overridden;
      win_addr_q  <= wr_addr_i;
      win_data_q  <= wr_data_i;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    AST_ZERO_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srca_addr_i[s] == '0) |-> (srca_data_o[s] == '0)); // R3
    AST_ONE_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srcb_addr_i[s] == ADDR_W'(1)) |-> (srcb_data_o[s] == DATA_W'(1))); // R3
    AST_COMMIT_NEEDS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_commit[s] |-> (wr_en_i[s] && guard_data_o[s][0])); // R4
    AST_FIXED_NOT_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_commit[s] |-> (wr_addr_i[s] > ADDR_W'(1))); // R5
    AST_WINNER_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_valid_q[s] && (srca_addr_i[s] == win_addr_q[s])) |->
        (srca_data_o[s] == win_data_q[s])); // R6
  end

  AST_CONFLICT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_now |=> conflict_o); // R7
  AST_NO_SPURIOUS_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conflict_now |=> !conflict_o); // R7

endmodule

bind gprf_top gprf_checker #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .srca_addr_i    (srca_addr_i),
  .srca_data_o    (srca_data_o),
  .srcb_addr_i    (srcb_addr_i),
  .srcb_data_o    (srcb_data_o),
  .guard_data_o   (guard_data_o),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .slot_commit    (slot_commit),
  .slot_overridden(slot_overridden),
  .conflict_now   (conflict_now),
  .conflict_o     (conflict_o)
);

// File: tb/gprf_top_test.sv
`timescale 1ns/1ps
module gprf_top_test;

  localparam int S = 5;
  localparam int NREG = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [S-1:0][6:0]  g_addr, a_addr, b_addr, w_addr;
  logic [S-1:0][31:0] g_data, a_data, b_data, w_data;
  logic [S-1:0]       w_en;
  logic               conflict;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] model [NREG];
  bit          model_ok [NREG];
  logic [S-1:0] exp_commit;
  bit           exp_conflict;

  always #2.5 clk = ~clk;

  gprf_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .guard_addr_i(g_addr), .guard_data_o(g_data),
    .srca_addr_i(a_addr),  .srca_data_o(a_data),
    .srcb_addr_i(b_addr),  .srcb_data_o(b_data),
    .wr_en_i(w_en), .wr_addr_i(w_addr), .wr_data_i(w_data),
    .conflict_o(conflict)
  );

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    if (a == 7'd0) return 32'd0;
    if (a == 7'd1) return 32'd1;
    return model[a];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    for (int s = 0; s < S; s++) begin
      w_en[s] = 1'b0; w_addr[s] = 7'd2; w_data[s] = '0;
      g_addr[s] = 7'd1; a_addr[s] = 7'd0; b_addr[s] = 7'd1;
    end
  endtask

  function automatic bit written_now(input logic [6:0] a);
    for (int s = 0; s < S; s++) if (exp_commit[s] && w_addr[s] == a) return 1;
    return 0;
  endfunction

  task automatic chk_read(input logic [6:0] a, input logic [31:0] got);
    string tag;
    if (a < 7'd2 || model_ok[a]) begin
      tag = (a < 7'd2) ? "R3" : (written_now(a) ? "R8" : "R1/R2");
      check(got === exp_read(a), tag, got, exp_read(a));
    end
  endtask

  // Inputs are set after a falling edge; this runs one clock and returns at the next falling edge.
  task automatic run_cycle();
    #1;
    exp_conflict = 0;
    for (int s = 0; s < S; s++)
      exp_commit[s] = w_en[s] && exp_read(g_addr[s])[0] && (w_addr[s] > 7'd1);
    for (int i = 0; i < S; i++)
      for (int j = i + 1; j < S; j++)
        if (exp_commit[i] && exp_commit[j] && w_addr[i] == w_addr[j]) exp_conflict = 1;
    for (int s = 0; s < S; s++) begin
      chk_read(g_addr[s], g_data[s]);
      chk_read(a_addr[s], a_data[s]);
      chk_read(b_addr[s], b_data[s]);
    end
    @(posedge clk);
    for (int s = 0; s < S; s++)
      if (exp_commit[s]) begin model[w_addr[s]] = w_data[s]; model_ok[w_addr[s]] = 1; end
    @(negedge clk);
    check(conflict === exp_conflict, "R7", {31'd0, conflict}, {31'd0, exp_conflict});
  endtask

  task automatic set_wr(input int s, input logic [6:0] a, input logic [31:0] d, input logic [6:0] g);
    w_en[s] = 1'b1; w_addr[s] = a; w_data[s] = d; g_addr[s] = g;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h1F2E3D4C);
    for (int r = 0; r < NREG; r++) begin model[r] = '0; model_ok[r] = 0; end
    exp_commit = '0;
    clear_inputs();
    repeat (3) @(negedge clk);
    check(conflict === 1'b0, "R9", {31'd0, conflict}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every writable register, unguarded (guard = register 1).
    for (int base = 2; base < NREG; base += S) begin
      clear_inputs();
      for (int s = 0; s < S; s++)
        if (base + s < NREG) set_wr(s, 7'(base + s), 32'hA5000000 ^ (32'(base + s) * 32'h00010203), 7'd1);
      run_cycle();
    end
    // Read back everything through all ports (R1).
    for (int base = 0; base < NREG; base += 3 * S) begin
      clear_inputs();
      for (int s = 0; s < S; s++) begin
        g_addr[s] = 7'((base + 3 * s) % NREG);
        a_addr[s] = 7'((base + 3 * s + 1) % NREG);
        b_addr[s] = 7'((base + 3 * s + 2) % NREG);
      end
      run_cycle();
    end

    // Guard values: reg10 even with upper bits set, reg11 odd.
    clear_inputs();
    set_wr(0, 7'd10, 32'hFFFFFFFE, 7'd1);
    set_wr(1, 7'd11, 32'h00000003, 7'd1);
    run_cycle();
    begin
      logic [31:0] old20, old22;
      old20 = model[20]; old22 = model[22];
      clear_inputs();
      set_wr(0, 7'd20, 32'h11111111, 7'd10);
      set_wr(1, 7'd21, 32'h22222222, 7'd11);
      set_wr(2, 7'd22, 32'h33333333, 7'd0);
      set_wr(3, 7'd0,  32'hDEADBEEF, 7'd1);
      set_wr(4, 7'd1,  32'hCAFEF00D, 7'd1);
      a_addr[0] = 7'd21;               // read during its own write: old value
      run_cycle();
      clear_inputs();
      a_addr[0] = 7'd20; a_addr[1] = 7'd21; a_addr[2] = 7'd22;
      a_addr[3] = 7'd0;  b_addr[3] = 7'd1;
      #1;
      check(a_data[0] === old20, "R4", a_data[0], old20);
      check(a_data[1] === 32'h22222222, "R4", a_data[1], 32'h22222222);
      check(a_data[2] === old22, "R4", a_data[2], old22);
      check(a_data[3] === 32'd0, "R5", a_data[3], 32'd0);
      check(b_data[3] === 32'd1, "R5", b_data[3], 32'd1);
      run_cycle();
    end

    // Same-register collisions: slots 1 and 3 on reg30, slots 0 and 4 on reg31.
    clear_inputs();
    set_wr(1, 7'd30, 32'h0000AAAA, 7'd1);
    set_wr(3, 7'd30, 32'h0000BBBB, 7'd1);
    set_wr(0, 7'd31, 32'h0000CCCC, 7'd1);
    set_wr(4, 7'd31, 32'h0000DDDD, 7'd1);
    run_cycle();
    check(conflict === 1'b1, "R7", {31'd0, conflict}, 32'd1);
    clear_inputs();
    a_addr[2] = 7'd30; b_addr[2] = 7'd31;
    #1;
    check(a_data[2] === 32'h0000BBBB, "R6", a_data[2], 32'h0000BBBB);
    check(b_data[2] === 32'h0000DDDD, "R6", b_data[2], 32'h0000DDDD);
    // Collision where one side is guarded off: no conflict.
    set_wr(0, 7'd40, 32'h1, 7'd10);
    set_wr(2, 7'd40, 32'h2, 7'd1);
    run_cycle();
    check(conflict === 1'b0, "R7", {31'd0, conflict}, 32'd0);

    // Reset right after a conflict: flag clears, storage kept.
    clear_inputs();
    set_wr(1, 7'd50, 32'h5, 7'd1);
    set_wr(2, 7'd50, 32'h6, 7'd1);
    run_cycle();
    rst_n = 1'b0;
    clear_inputs();
    #1;
    check(conflict === 1'b0, "R9", {31'd0, conflict}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    a_addr[0] = 7'd30; b_addr[0] = 7'd50;
    #1;
    check(a_data[0] === 32'h0000BBBB, "R9", a_data[0], 32'h0000BBBB);
    check(b_data[0] === 32'h6, "R9", b_data[0], 32'h6);
    @(negedge clk);

    // Random traffic concentrated on a small window of registers.
    for (int n = 0; n < 4000; n++) begin
      for (int s = 0; s < S; s++) begin
        w_en[s]   = ($urandom % 4) != 0;
        w_addr[s] = (($urandom % 10) == 0) ? 7'($urandom % 2) : 7'(2 + $urandom % 14);
        w_data[s] = $urandom;
        g_addr[s] = (($urandom % 8) == 0) ? 7'($urandom % 2) : 7'(2 + $urandom % 14);
        a_addr[s] = 7'($urandom % 128);
        b_addr[s] = 7'(2 + $urandom % 14);
      end
      run_cycle();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule